// File: doc/BRIEF.md
# Wakeup Event Detector Bank

This block watches a set of input pins on behalf of a power controller and raises a power-up request when any of its wakeup channels sees its trigger condition. There are four channels by default. Each one picks a single pin out of a 54-wide pin vector through a 6-bit selector, where codes 0 to 47 reach general pins and codes 48 to 53 reach six flash interface lines. Each channel then detects either a level or an edge of a chosen polarity. A level trigger tracks the pin. An edge trigger stays latched until software clears it explicitly or turns the channel off.

Besides the pin channels, the block takes a debug power-up request and a timer alarm. The alarm latches while its enable is held and drops when the enable is removed. A source encoder merges all pending requests into one request line and a 3-bit code that names the winning source. When a core power-up starts, that code is copied into a register and held there until the next power-up. Pin inputs are assumed to be synchronised upstream. Each channel is configured by a write strobe plus a shared write word, and it is read back through a packed status vector.

Top module: `wake_detect_bank`

## Requirements
- R1: A selector value of 54 or more picks no pin. Such a channel never raises an event, whatever the pin levels, and its raw bit reads 0.
- R2: In level mode (mode bit 0), a channel's status is the selected pin compared against the direction bit, one clock after the pin value is sampled. Direction 1 means active high and direction 0 means active low.
- R3: In edge mode (mode bit 1), direction 1 latches status on a 0-to-1 change of the selected pin and direction 0 latches on a 1-to-0 change. The latched status stays set after the pin returns. The first clock after a configuration write never detects an edge.
- R4: A configuration write with write-word bit 9 set clears the channel's status on that clock.
- R5: A configuration write with the enable bit (bit 6) at 0 disables the channel and clears its pending status on that clock.
- R6: The raw bit shows the selected pin's value while the channel is enabled. It reads 0 while the channel is disabled.
- R7: Each channel occupies 11 readback bits: selector in 5:0, enable in 6, direction in 7, mode in 8, status in 9 and raw in 10. Write-word bits 8:0 load the same fields.
- R8: The source code is 0 when nothing is pending, 1 to 4 for channels 0 to 3, 5 for the debug request and 6 for the alarm. The lowest pending code wins. The request output is high exactly when the code is non-zero.
- R9: An alarm pulse that arrives while the alarm enable is high latches an alarm request. The request is cleared on the first clock the enable is low.
- R10: On each clock with the power-up start strobe high, the last-power-up code takes the current source code. It holds that value at all other times.
- R11: After reset, all channel fields, the request, the current code and the last-power-up code are 0. A last code of 0 means the power-up came from a chip reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 54 | Synchronised pin vector; bits 48 to 53 are flash lines |
| cfg_we_i | input | 4 | Per-channel configuration write strobe |
| cfg_wdata_i | input | 10 | Shared write word: fields 8:0, status clear in bit 9 |
| chan_rd_o | output | 44 | Packed readback, 11 bits per channel, channel 0 lowest |
| dbg_pwrup_i | input | 1 | Debug power-up request (level) |
| alarm_fire_i | input | 1 | Alarm fired pulse |
| alarm_en_i | input | 1 | Alarm wake enable; low clears the alarm request |
| pwrup_start_i | input | 1 | Strobe marking the start of a core power-up |
| wake_req_o | output | 1 | Any wakeup source pending |
| cur_src_o | output | 3 | Code of the winning pending source |
| last_src_o | output | 3 | Code captured at the last power-up start |

## Verification
The assertions check the following relations on every clock:
- a disabling write or a status-clear write empties the channel's status on the next clock;
- a latched edge holds while the channel is left alone;
- a selector that is out of range keeps the raw bit at 0;
- the request line agrees with the code;
- the alarm code is gone one clock after its enable falls;
- the last-power-up code either copies the current code on a start strobe or stays unchanged.

The bench scenarios cover what a per-cycle relation cannot show:
- every selector value, in both polarities, reaching exactly one pin and no neighbour;
- the difference between a level trigger and an edge trigger over whole pin sequences;
- the blind clock after a configuration write;
- lowest-code priority across all 64 combinations of the six request sources.

// File: rtl/wake_pkg.sv
package wake_pkg;
   // selector and configuration geometry shared by channel, top and checker
   localparam int SEL_W  = 6;
   localparam int F_EN   = 6;
   localparam int F_DIR  = 7;
   localparam int F_MODE = 8;
   localparam int F_STAT = 9;
   localparam int F_RAW  = 10;
   localparam int CFG_W  = F_STAT + 1;
   localparam int RD_W   = F_RAW + 1;

   typedef struct packed {
      logic             mode;   // 0 level, 1 edge
      logic             dir;    // 0 low/falling, 1 high/rising
      logic             en;
      logic [SEL_W-1:0] src;
   } chan_cfg_t;
endpackage

// File: rtl/wake_channel.sv
module wake_channel
   import wake_pkg::*;
#(
   parameter int NUM_PIN = 54
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_PIN-1:0] pins_i,
   input  logic               we_i,
   input  logic [CFG_W-1:0]   wdata_i,
   output logic               req_o,
   output logic [RD_W-1:0]    rd_o
);
   chan_cfg_t cfg_q;
   logic      stat_q;
   logic      prev_q;
   logic      arm_q;
   logic      sel_ok;
   logic      pin_now;
   logic      hit_lvl;
   logic      hit_edge;

   // selector decode: codes past the pin count reach nothing
   always_comb begin
      sel_ok  = 1'b0;
      pin_now = 1'b0;
      for (int i = 0; i < NUM_PIN; i++) begin
         if (cfg_q.src == SEL_W'(i)) begin
            sel_ok  = 1'b1;
            pin_now = pins_i[i];
         end
      end
   end

   assign hit_lvl  = cfg_q.en & sel_ok & (pin_now == cfg_q.dir);
   assign hit_edge = cfg_q.en & sel_ok & arm_q & (pin_now != prev_q) & (pin_now == cfg_q.dir);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         stat_q <= 1'b0;
         prev_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         prev_q <= pin_now;
         arm_q  <= ~we_i;
         if (we_i) begin
            cfg_q <= chan_cfg_t'(wdata_i[F_MODE:0]);
            if (!wdata_i[F_EN] || wdata_i[F_STAT])
               stat_q <= 1'b0;
         end else if (cfg_q.mode) begin
            if (!cfg_q.en)
               stat_q <= 1'b0;
            else if (hit_edge)
               stat_q <= 1'b1;
         end else begin
            stat_q <= hit_lvl;
         end
      end
   end

   assign req_o = stat_q;
   assign rd_o  = {cfg_q.en & pin_now, stat_q, cfg_q};
endmodule

// File: rtl/wake_src_encoder.sv
module wake_src_encoder #(
   parameter int NREQ      = 6,
   parameter int CODE_W    = 3,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NREQ-1:0]   req_i,
   input  logic              pwrup_start_i,
   output logic              any_o,
   output logic [CODE_W-1:0] cur_o,
   output logic [CODE_W-1:0] last_o
);
   logic [CODE_W-1:0] last_q;

   // request bit i carries code i+1; code 0 means nothing pending
   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            cur_o = '0;
            for (int i = NREQ - 1; i >= 0; i--)
               if (req_i[i]) cur_o = CODE_W'(i + 1);
         end
      end else begin : g_high
         always_comb begin
            cur_o = '0;
            for (int i = 0; i < NREQ; i++)
               if (req_i[i]) cur_o = CODE_W'(i + 1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         last_q <= '0;
      else if (pwrup_start_i)
         last_q <= cur_o;
   end

   assign any_o  = |req_i;
   assign last_o = last_q;
endmodule

// File: rtl/wake_detect_bank.sv
module wake_detect_bank
   import wake_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int NUM_GPIO  = 48,
   parameter int NUM_FLASH = 6,
   parameter int SRC_W     = 3,
   parameter bit LOW_FIRST = 1'b1,
   localparam int NUM_PIN  = NUM_GPIO + NUM_FLASH,
   localparam int NREQ     = NUM_CH + 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_PIN-1:0]     pins_i,
   input  logic [NUM_CH-1:0]      cfg_we_i,
   input  logic [CFG_W-1:0]       cfg_wdata_i,
   output logic [NUM_CH*RD_W-1:0] chan_rd_o,
   input  logic                   dbg_pwrup_i,
   input  logic                   alarm_fire_i,
   input  logic                   alarm_en_i,
   input  logic                   pwrup_start_i,
   output logic                   wake_req_o,
   output logic [SRC_W-1:0]       cur_src_o,
   output logic [SRC_W-1:0]       last_src_o
);
   // elaboration checks on the configuration
   generate
      if (NUM_PIN > (1 << SEL_W)) begin : g_bad_pins
         $error("pin count exceeds selector range");
      end
      if (NREQ + 1 > (1 << SRC_W)) begin : g_bad_code
         $error("source code too narrow for request count");
      end
      if (NUM_CH < 1) begin : g_bad_ch
         $error("need at least one channel");
      end
   endgenerate

   logic [NREQ-1:0] req_vec;
   logic            alarm_q;

   genvar c;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_ch
         wake_channel #(.NUM_PIN(NUM_PIN)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .pins_i  (pins_i),
            .we_i    (cfg_we_i[c]),
            .wdata_i (cfg_wdata_i),
            .req_o   (req_vec[c]),
            .rd_o    (chan_rd_o[c*RD_W +: RD_W])
         );
      end
   endgenerate

   // alarm request: latched on fire, dropped with its enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         alarm_q <= 1'b0;
      else if (!alarm_en_i)
         alarm_q <= 1'b0;
      else if (alarm_fire_i)
         alarm_q <= 1'b1;
   end

   assign req_vec[NUM_CH]     = dbg_pwrup_i;
   assign req_vec[NUM_CH + 1] = alarm_q;

   wake_src_encoder #(
      .NREQ      (NREQ),
      .CODE_W    (SRC_W),
      .LOW_FIRST (LOW_FIRST)
   ) u_enc (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_i         (req_vec),
      .pwrup_start_i (pwrup_start_i),
      .any_o         (wake_req_o),
      .cur_o         (cur_src_o),
      .last_o        (last_src_o)
   );
endmodule

// File: rtl/wake_detect_bank_chk.sv
module wake_detect_bank_chk
   import wake_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int NUM_PIN = 54,
   parameter int SRC_W   = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_CH-1:0]      cfg_we_i,
   input logic [CFG_W-1:0]       cfg_wdata_i,
   input logic [NUM_CH*RD_W-1:0] chan_rd_o,
   input logic                   dbg_pwrup_i,
   input logic                   alarm_en_i,
   input logic                   pwrup_start_i,
   input logic                   wake_req_o,
   input logic [SRC_W-1:0]       cur_src_o,
   input logic [SRC_W-1:0]       last_src_o
);
   localparam logic [SRC_W-1:0] CODE_ALARM = SRC_W'(NUM_CH + 2);
   localparam logic [SRC_W-1:0] CODE_DEBUG = SRC_W'(NUM_CH + 1);

   genvar c;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_chk
         p_disable_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we_i[c] && !cfg_wdata_i[F_EN]) |=> !chan_rd_o[c*RD_W + F_STAT]);
         p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we_i[c] && cfg_wdata_i[F_STAT]) |=> !chan_rd_o[c*RD_W + F_STAT]);
         p_edge_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_rd_o[c*RD_W + F_MODE] && chan_rd_o[c*RD_W + F_EN] &&
             chan_rd_o[c*RD_W + F_STAT] && !cfg_we_i[c]) |=> chan_rd_o[c*RD_W + F_STAT]);
         p_bad_sel_raw_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(chan_rd_o[c*RD_W +: SEL_W]) >= NUM_PIN) |-> !chan_rd_o[c*RD_W + F_RAW]);
      end
   endgenerate

   p_req_matches_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req_o == (cur_src_o != '0));
   p_debug_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_pwrup_i |-> (cur_src_o != '0 && cur_src_o <= CODE_DEBUG));
   p_alarm_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !alarm_en_i |=> (cur_src_o != CODE_ALARM));
   p_last_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pwrup_start_i |=> (last_src_o == $past(cur_src_o)));
   p_last_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pwrup_start_i |=> $stable(last_src_o));
endmodule

bind wake_detect_bank wake_detect_bank_chk #(
   .NUM_CH  (NUM_CH),
   .NUM_PIN (NUM_PIN),
   .SRC_W   (SRC_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_we_i      (cfg_we_i),
   .cfg_wdata_i   (cfg_wdata_i),
   .chan_rd_o     (chan_rd_o),
   .dbg_pwrup_i   (dbg_pwrup_i),
   .alarm_en_i    (alarm_en_i),
   .pwrup_start_i (pwrup_start_i),
   .wake_req_o    (wake_req_o),
   .cur_src_o     (cur_src_o),
   .last_src_o    (last_src_o)
);

// File: tb/test_wake_detect_bank.sv
module test_wake_detect_bank;
   localparam int NCH  = 4;
   localparam int NPIN = 54;
   localparam int RDW  = 11;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NPIN-1:0] pins = '0;
   logic [NCH-1:0]  cfg_we = '0;
   logic [9:0]      cfg_wdata = '0;
   logic [NCH*RDW-1:0] chan_rd;
   logic            dbg = 1'b0;
   logic            al_fire = 1'b0;
   logic            al_en = 1'b0;
   logic            pw_start = 1'b0;
   logic            wake_req;
   logic [2:0]      cur_src;
   logic [2:0]      last_src;

   int checks = 0;
   int errors = 0;
   bit timed_out = 1'b0;

   always #10 clk = ~clk;

   wake_detect_bank i_wake_detect_bank (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .cfg_we_i(cfg_we),
      .cfg_wdata_i(cfg_wdata), .chan_rd_o(chan_rd), .dbg_pwrup_i(dbg),
      .alarm_fire_i(al_fire), .alarm_en_i(al_en), .pwrup_start_i(pw_start),
      .wake_req_o(wake_req), .cur_src_o(cur_src), .last_src_o(last_src)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic write_cfg(input int ch, input logic [9:0] data);
      @(negedge clk);
      cfg_we = NCH'(1) << ch;
      cfg_wdata = data;
      @(negedge clk);
      cfg_we = '0;
   endtask

   function automatic logic stat(input int ch);
      return chan_rd[ch*RDW + 9];
   endfunction

   function automatic logic raw(input int ch);
      return chan_rd[ch*RDW + 10];
   endfunction

   function automatic logic [9:0] mk(input logic mode, input logic dir, input logic en, input int src);
      return {1'b0, mode, dir, en, 6'(src)};
   endfunction

   task automatic run();
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R11 reset state
      chk("R11 readback", chan_rd, 0);
      chk("R11 wake_req", wake_req, 0);
      chk("R11 cur_src", cur_src, 0);
      chk("R11 last_src", last_src, 0);

      // R1 R2 R6 R7: every selector value, both polarities, level mode on channel 0
      for (int s = 0; s < 64; s++) begin
         for (int d = 0; d < 2; d++) begin
            bit ok;
            ok = (s < NPIN);
            write_cfg(0, mk(1'b0, d[0], 1'b1, s));
            chk("R7 field layout", chan_rd[8:0], {d[0], 1'b1, 6'(s)} | 9'h000);
            pins = '1;
            if (ok) pins[s] = 1'b0;
            step();
            chk("R2/R1 level selected low", stat(0), ok && d == 0);
            chk("R6 raw low", raw(0), 0);
            chk("R8 code", cur_src, (ok && d == 0) ? 1 : 0);
            pins = '0;
            if (ok) pins[s] = 1'b1;
            step();
            chk("R2/R1 level selected high", stat(0), ok && d == 1);
            chk("R6/R1 raw high", raw(0), ok);
            if (ok) begin
               pins = '0;
               pins[(s + 1) % NPIN] = 1'b1;
               step();
               chk("R1 neighbour not selected", raw(0), 0);
            end
         end
      end
      pins = '0;
      write_cfg(0, mk(1'b0, 1'b1, 1'b0, 3));
      pins[3] = 1'b1;
      step();
      chk("R6 raw gated by enable", raw(0), 0);
      chk("R5 disabled level idle", stat(0), 0);
      pins = '0;

      // R3 R4 R5: edge mode on channel 1, rising, flash line 50
      write_cfg(1, mk(1'b1, 1'b1, 1'b1, 50));
      step();
      pins[50] = 1'b1;
      step();
      chk("R3 rising latched", stat(1), 1);
      chk("R8 channel1 code", cur_src, 2);
      pins[50] = 1'b0;
      step();
      chk("R3 held after pin drops", stat(1), 1);
      write_cfg(1, 10'h200 | mk(1'b1, 1'b1, 1'b1, 50));
      chk("R4 w1c clears", stat(1), 0);
      step();
      pins[50] = 1'b1;
      step();
      pins[50] = 1'b0;
      step();
      chk("R3 re-latched", stat(1), 1);
      write_cfg(1, mk(1'b1, 1'b1, 1'b1, 50));
      chk("R4 write without clear keeps edge", stat(1), 1);
      write_cfg(1, mk(1'b1, 1'b1, 1'b0, 50));
      chk("R5 disable clears edge", stat(1), 0);
      chk("R8 idle after disable", cur_src, 0);

      // falling edge on pin 5, and the blind clock after a write
      pins[5] = 1'b1;
      write_cfg(1, mk(1'b1, 1'b0, 1'b1, 5));
      pins[5] = 1'b0;
      step();
      chk("R3 no edge in clock after write", stat(1), 0);
      pins[5] = 1'b1;
      step();
      chk("R3 rising ignored by falling channel", stat(1), 0);
      pins[5] = 1'b0;
      step();
      chk("R3 falling latched", stat(1), 1);
      write_cfg(1, mk(1'b1, 1'b0, 1'b0, 5));
      chk("R5 disable clears falling", stat(1), 0);

      // R8 R9: every combination of the six request sources
      for (int c = 0; c < NCH; c++) write_cfg(c, mk(1'b0, 1'b1, 1'b1, c));
      for (int m = 0; m < 64; m++) begin
         int exp_code;
         pins = '0;
         pins[3:0] = m[3:0];
         dbg = m[4];
         al_en = m[5];
         al_fire = m[5];
         step();
         exp_code = 0;
         for (int b = 5; b >= 0; b--) if (m[b]) exp_code = b + 1;
         chk("R8 priority code", cur_src, exp_code);
         chk("R8 request line", wake_req, m != 0);
      end
      pins = '0; dbg = 1'b0; al_en = 1'b0; al_fire = 1'b0;
      step();

      // R9: alarm latch and clear by enable
      al_en = 1'b1; al_fire = 1'b1;
      step();
      al_fire = 1'b0;
      step();
      chk("R9 alarm latched", cur_src, 6);
      al_en = 1'b0;
      step();
      chk("R9 alarm cleared by enable", cur_src, 0);
      al_en = 1'b1;
      step();
      chk("R9 no re-arm without fire", cur_src, 0);
      al_en = 1'b0;

      // R10: last power-up source
      pins[2] = 1'b1;
      step();
      chk("R10 before capture", last_src, 0);
      pw_start = 1'b1;
      step();
      pw_start = 1'b0;
      chk("R10 captured channel2", last_src, 3);
      pins[2] = 1'b0; pins[0] = 1'b1;
      step();
      step();
      chk("R10 holds after source change", last_src, 3);
      chk("R8 new current", cur_src, 1);
      pw_start = 1'b1;
      step();
      pw_start = 1'b0;
      chk("R10 recaptured channel0", last_src, 1);
      pins = '0;
      step();
      step();
      chk("R10 holds when idle", last_src, 1);
   endtask

   initial begin
      fork
         run();
         begin
            repeat (150000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      if (timed_out) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=done");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule